// File: doc/BRIEF.md
# Glitch-Free System Clock Selector

This block chooses which of two oscillators drives the system clock: a fast main oscillator or a slow secondary one. Software asks for a source by writing a one-bit select field in an 8-bit control register. Whenever the select bit and the source in use disagree, the block freezes the core. It then closes the gate of the old clock and counts rising edges of the new clock. Only after that does it open the new gate and release the freeze. The output therefore never carries a runt pulse, and the two clock gates are never open at the same time.

When the block returns to the main oscillator, it first adds a start-up wait that depends on the main oscillator's mode code. Crystal-type modes add a fixed start-up count. The PLL mode adds a further lock count on top of that. Modes that use an external clock or an RC network add no wait and go straight to edge counting. Two configuration inputs gate the select bit: a switch-disable strap, which is 1 when the part is erased, and the secondary-oscillator enable. The register and the control logic run on the main clock.

Top module: `sysclk_switch`

## Requirements
- R1: The read value carries the select bit in bit 0, and bits 7..1 always read 0, whatever was written there.
- R2: A write stores wr_data[0] into the select bit only when cfg_swap_off is 0 and sec_osc_on is 1. In any other case the written value is not stored and the bit reads 0.
- R3: If cfg_swap_off becomes 1 or sec_osc_on becomes 0 while the select bit is 1, the bit is cleared on the next main clock edge.
- R4: During and after reset, the select bit is 0, the core is not frozen, and sys_clk follows clk_main.
- R5: core_frozen rises on the main clock edge that follows a change of the select bit. While it is high, sys_clk gives at most 3 further rising edges, all from the old source.
- R6: On a switch to the secondary oscillator, core_frozen stays high for at least 8 rising edges of clk_sec.
- R7: On a switch to the main oscillator with a mode code of 4 to 7 (RC, RC with I/O pin, external clock, external clock with I/O pin), there is no start-up wait. core_frozen lasts at least 8 and fewer than OST_CYCLES main clock cycles.
- R8: With mode code 0, 1 or 2 (low-power crystal, crystal, high-speed crystal), the freeze before returning to main lasts at least OST_CYCLES + 8 main cycles and fewer than OST_CYCLES + PLL_LOCK_CYCLES.
- R9: With mode code 3 (high-speed crystal with PLL), the freeze lasts at least OST_CYCLES + PLL_LOCK_CYCLES + 8 main cycles.
- R10: sys_clk never has a high or low phase shorter than half a main clock period, and the two clock gates are never enabled together.
- R11: After core_frozen falls, sys_clk runs at the period of the source that the select bit names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator clock; also clocks the register and the controller |
| clk_sec | input | 1 | Low-frequency secondary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_swap_off | input | 1 | Configuration strap; 1 disables clock switching (erased default) |
| sec_osc_on | input | 1 | Secondary oscillator enable |
| cfg_main_mode | input | 3 | Main oscillator mode code (0 LP, 1 XT, 2 HS, 3 HS+PLL, 4 RC, 5 RC+IO, 6 EC, 7 EC+IO) |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register readback |
| sys_clk | output | 1 | Gated system clock |
| core_frozen | output | 1 | High while a handover is in progress |

## Verification
On every main clock edge, the bound checker confirms several things. The select bit is only ever 1 when the previous cycle allowed it. A pending mismatch always raises the freeze on the next edge. The active source changes only on the edge where the freeze ends. The two gate enables are never both on. Handovers to a crystal or PLL main mode are preceded by enough frozen cycles. Other properties span both clock domains or are measured in time, so only the bench scenarios can show them: the number of clk_sec edges counted during a freeze, the shortest sys_clk phase, the sys_clk period after a handover, and the edges that sys_clk still gives after the freeze starts.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DRAIN = 3'd1,
    ST_OSC   = 3'd2,
    ST_LOCK  = 3'd3,
    ST_SYNC  = 3'd4
  } cs_state_e;

  // crystal-type main modes (codes 0..3) need the start-up wait
  function automatic logic mode_has_startup(input logic [2:0] m);
    return (m[2] == 1'b0);
  endfunction

  // code 3 is the high-speed crystal followed by the PLL
  function automatic logic mode_has_lock(input logic [2:0] m);
    return (m == 3'b011);
  endfunction

  // least number of frozen main cycles before a handover to main
  function automatic int unsigned main_freeze_floor(input logic [2:0] m,
                                                    input int unsigned ost,
                                                    input int unsigned pll,
                                                    input int unsigned edges);
    int unsigned n;
    n = edges;
    if (mode_has_startup(m)) n = n + ost;
    if (mode_has_lock(m))    n = n + pll;
    return n;
  endfunction

endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cs_gate.sv
`timescale 1ns/1ps
module cs_gate #(
  parameter bit CROSS  = 1'b1,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic en,
  output logic clk_out
);
  logic want_s;

  generate
    if (CROSS) begin : g_sync
      cs_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst_n(rst_n), .d(want), .q(want_s));
    end else begin : g_direct
      assign want_s = want;
    end
  endgenerate

  // enable changes only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= want_s;
  end

  assign clk_out = clk & en;
endmodule

// File: rtl/cs_edge_cnt.sv
`timescale 1ns/1ps
module cs_edge_cnt #(
  parameter int EDGES  = 8,
  parameter bit CROSS  = 1'b1,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic done
);
  localparam int CW = $clog2(EDGES + 1);

  logic          go_s;
  logic [CW-1:0] cnt;

  generate
    if (CROSS) begin : g_sync
      cs_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst_n(rst_n), .d(go), .q(go_s));
    end else begin : g_direct
      assign go_s = go;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!go_s)                cnt <= '0;
    else if (cnt != CW'(EDGES))    cnt <= cnt + 1'b1;
  end

  assign done = (cnt == CW'(EDGES));
endmodule

// File: rtl/cs_ctrl.sv
`timescale 1ns/1ps
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [2:0] mode,
  input  logic       main_off,
  input  logic       sec_off,
  input  logic       main_done,
  input  logic       sec_done,
  output logic       frozen,
  output logic       cur_src,
  output logic       tgt,
  output logic       go_main,
  output logic       go_sec,
  output logic       want_main,
  output logic       want_sec,
  output logic       handover
);
  localparam int MAXW = (OST_CYCLES > PLL_LOCK_CYCLES) ? OST_CYCLES : PLL_LOCK_CYCLES;
  localparam int CW   = $clog2(MAXW + 1);

  cs_state_e     state;
  logic [CW-1:0] cnt;
  logic          drained;

  assign frozen    = (state != ST_RUN);
  assign drained   = main_off && sec_off && !main_done && !sec_done;
  assign go_main   = (state == ST_SYNC) && !tgt;
  assign go_sec    = (state == ST_SYNC) &&  tgt;
  assign handover  = (state == ST_SYNC) && (tgt ? sec_done : main_done);
  assign want_main = !frozen && !cur_src;
  assign want_sec  = !frozen &&  cur_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      cnt     <= '0;
      cur_src <= 1'b0;
      tgt     <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: if (sel != cur_src) begin
          tgt   <= sel;
          state <= ST_DRAIN;
        end
        ST_DRAIN: if (drained) begin
          cnt   <= '0;
          state <= (!tgt && mode_has_startup(mode)) ? ST_OSC : ST_SYNC;
        end
        ST_OSC: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(OST_CYCLES - 1)) begin
            cnt   <= '0;
            state <= mode_has_lock(mode) ? ST_LOCK : ST_SYNC;
          end
        end
        ST_LOCK: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(PLL_LOCK_CYCLES - 1)) begin
            cnt   <= '0;
            state <= ST_SYNC;
          end
        end
        ST_SYNC: if (handover) begin
          cur_src <= tgt;
          state   <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch #(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 2000,
  parameter int SYNC_EDGES      = 8,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk_main,
  input  logic       clk_sec,
  input  logic       rst_n,
  input  logic       cfg_swap_off,
  input  logic       sec_osc_on,
  input  logic [2:0] cfg_main_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_clk,
  output logic       core_frozen
);
  logic sel_q, permit;
  logic frozen, cur_src, tgt, handover;
  logic go_main, go_sec, want_main, want_sec;
  logic gate_main_en, gate_sec_en, gate_sec_en_s;
  logic clk_main_g, clk_sec_g;
  logic main_done, sec_done, sec_done_s;
  logic unused_hi;

  assign permit    = !cfg_swap_off && sec_osc_on;
  assign unused_hi = ^wr_data[7:1];

  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (!permit) sel_q <= 1'b0;
    else if (wr_en)   sel_q <= wr_data[0];
  end

  assign rd_data = {7'd0, sel_q};

  cs_ctrl #(.OST_CYCLES(OST_CYCLES), .PLL_LOCK_CYCLES(PLL_LOCK_CYCLES)) u_ctrl (
    .clk(clk_main), .rst_n(rst_n), .sel(sel_q), .mode(cfg_main_mode),
    .main_off(!gate_main_en), .sec_off(!gate_sec_en_s),
    .main_done(main_done), .sec_done(sec_done_s),
    .frozen(frozen), .cur_src(cur_src), .tgt(tgt),
    .go_main(go_main), .go_sec(go_sec),
    .want_main(want_main), .want_sec(want_sec), .handover(handover));

  cs_gate #(.CROSS(1'b0), .STAGES(SYNC_STAGES)) u_gate_main (
    .clk(clk_main), .rst_n(rst_n), .want(want_main), .en(gate_main_en), .clk_out(clk_main_g));
  cs_gate #(.CROSS(1'b1), .STAGES(SYNC_STAGES)) u_gate_sec (
    .clk(clk_sec), .rst_n(rst_n), .want(want_sec), .en(gate_sec_en), .clk_out(clk_sec_g));

  cs_edge_cnt #(.EDGES(SYNC_EDGES), .CROSS(1'b0), .STAGES(SYNC_STAGES)) u_cnt_main (
    .clk(clk_main), .rst_n(rst_n), .go(go_main), .done(main_done));
  cs_edge_cnt #(.EDGES(SYNC_EDGES), .CROSS(1'b1), .STAGES(SYNC_STAGES)) u_cnt_sec (
    .clk(clk_sec), .rst_n(rst_n), .go(go_sec), .done(sec_done));

  cs_sync #(.STAGES(SYNC_STAGES)) u_sync_sec_en (
    .clk(clk_main), .rst_n(rst_n), .d(gate_sec_en), .q(gate_sec_en_s));
  cs_sync #(.STAGES(SYNC_STAGES)) u_sync_sec_done (
    .clk(clk_main), .rst_n(rst_n), .d(sec_done), .q(sec_done_s));

  assign sys_clk     = clk_main_g | clk_sec_g;
  assign core_frozen = frozen;
endmodule

// File: rtl/sysclk_switch_chk.sv
`timescale 1ns/1ps
module sysclk_switch_chk
  import cs_pkg::*;
#(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 2000,
  parameter int SYNC_EDGES      = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_swap_off,
  input logic       sec_osc_on,
  input logic [2:0] mode,
  input logic       sel,
  input logic       frozen,
  input logic       cur_src,
  input logic       tgt,
  input logic       handover,
  input logic       gate_main_en,
  input logic       gate_sec_en
);
  int unsigned frz_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frz_cnt <= 0;
    else if (frozen) frz_cnt <= frz_cnt + 1;
    else             frz_cnt <= 0;
  end

  AST_SEL_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> $past(!cfg_swap_off && sec_osc_on)); // R3

  AST_FREEZE_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && sel != cur_src) |=> frozen); // R5

  AST_SRC_MOVES_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src != $past(cur_src)) |-> (!frozen && $past(frozen))); // R11

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_main_en, gate_sec_en})); // R10

  AST_STARTUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (handover && !tgt && mode_has_startup(mode)) |->
      (frz_cnt >= main_freeze_floor(mode, OST_CYCLES, 0, SYNC_EDGES))); // R8

  AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (handover && !tgt && mode_has_lock(mode)) |->
      (frz_cnt >= main_freeze_floor(mode, OST_CYCLES, PLL_LOCK_CYCLES, SYNC_EDGES))); // R9
endmodule

bind sysclk_switch sysclk_switch_chk #(
  .OST_CYCLES(OST_CYCLES), .PLL_LOCK_CYCLES(PLL_LOCK_CYCLES), .SYNC_EDGES(SYNC_EDGES)
) u_chk (
  .clk(clk_main), .rst_n(rst_n), .cfg_swap_off(cfg_swap_off), .sec_osc_on(sec_osc_on),
  .mode(cfg_main_mode), .sel(sel_q), .frozen(frozen), .cur_src(cur_src), .tgt(tgt),
  .handover(handover), .gate_main_en(gate_main_en), .gate_sec_en(gate_sec_en));

// File: tb/tb_sysclk_switch.sv
`timescale 1ns/1ps
module tb_sysclk_switch;
  localparam int  OST  = 1024;
  localparam int  PLL  = 300;
  localparam int  EDG  = 8;
  localparam real TMAIN = 20.0;
  localparam real TSEC  = 146.0;

  logic       clk_main = 0, clk_sec = 0, rst_n = 0;
  logic       cfg_swap_off = 1, sec_osc_on = 0;
  logic [2:0] cfg_main_mode = 3'd4;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       sys_clk, core_frozen;

  sysclk_switch #(.OST_CYCLES(OST), .PLL_LOCK_CYCLES(PLL), .SYNC_EDGES(EDG)) dut (
    .clk_main(clk_main), .clk_sec(clk_sec), .rst_n(rst_n), .cfg_swap_off(cfg_swap_off),
    .sec_osc_on(sec_osc_on), .cfg_main_mode(cfg_main_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sys_clk(sys_clk), .core_frozen(core_frozen));

  always #10 clk_main = ~clk_main;
  initial begin #3; forever #73 clk_sec = ~clk_sec; end

  int  n_chk = 0, n_fail = 0, cyc = 0;
  int  frz_main = 0, frz_sec = 0, frz_sys = 0;
  real t_last = -1.0, min_w = 1.0e9;
  logic sel_model = 0;

  always @(posedge clk_main) if (core_frozen) frz_main++;
  always @(posedge clk_sec)  if (core_frozen) frz_sec++;
  always @(posedge sys_clk)  if (core_frozen) frz_sys++;
  always @(sys_clk) begin
    if (t_last >= 0.0 && rst_n && ($realtime - t_last) < min_w) min_w = $realtime - t_last;
    t_last = $realtime;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_main) begin
    cyc++;
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit crystal(input logic [2:0] m); return m < 3'd4; endfunction
  function automatic bit pll_mode(input logic [2:0] m); return m == 3'd3; endfunction
  function automatic int win_lo(input logic [2:0] m);
    return EDG + (crystal(m) ? OST : 0) + (pll_mode(m) ? PLL : 0);
  endfunction
  function automatic int win_hi(input logic [2:0] m);
    return win_lo(m) - EDG + 60;
  endfunction

  task automatic measure(input real exp, input string req);
    real t0, dt;
    repeat (3) @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    dt = $realtime - t0;
    chk((dt > exp - 0.5) && (dt < exp + 0.5), req, "sys_clk period ns", int'(dt), int'(exp));
  endtask

  task automatic write(input logic [7:0] v);
    @(negedge clk_main); wr_en = 1; wr_data = v;
    @(negedge clk_main); wr_en = 0;
  endtask

  // called at the negedge right after the select bit changed
  task automatic wait_switch(input bit tgt, input logic [2:0] m);
    int k;
    frz_main = 0; frz_sec = 0; frz_sys = 0;
    k = 0;
    while (!core_frozen && k < 3) begin @(negedge clk_main); k++; end
    chk(core_frozen && k == 1, "R5", "freeze one edge after select change", k, 1);
    k = 0;
    while (core_frozen && k < 4000) begin @(negedge clk_main); k++; end
    chk(!core_frozen, "R5", "freeze released", core_frozen, 0);
    chk(frz_sys <= 3, "R5", "sys_clk edges while frozen", frz_sys, 3);
    if (tgt) begin
      chk(frz_sec >= EDG && frz_sec <= EDG + 6, "R6", "sec edges in freeze", frz_sec, EDG);
    end else if (pll_mode(m)) begin
      chk(frz_main >= win_lo(m) && frz_main <= win_hi(m), "R9", "freeze main cycles", frz_main, win_lo(m));
    end else if (crystal(m)) begin
      chk(frz_main >= win_lo(m) && frz_main < OST + PLL, "R8", "freeze main cycles", frz_main, win_lo(m));
    end else begin
      chk(frz_main >= win_lo(m) && frz_main < OST, "R7", "freeze main cycles", frz_main, win_lo(m));
    end
    measure(tgt ? TSEC : TMAIN, "R11");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk_main);
    chk(rd_data == 8'h00, "R4", "rd_data in reset", rd_data, 0);
    rst_n = 1;
    repeat (3) @(negedge clk_main);
    chk(rd_data == 8'h00, "R4", "rd_data after reset", rd_data, 0);
    chk(core_frozen == 0, "R4", "core_frozen after reset", core_frozen, 0);
    measure(TMAIN, "R4");

    // erased strap: write ignored
    sec_osc_on = 1;
    write(8'h01);
    chk(rd_data == 8'h00, "R2", "write with switching disabled", rd_data, 0);
    repeat (3) @(negedge clk_main);
    chk(core_frozen == 0, "R2", "no freeze after ignored write", core_frozen, 0);
    // secondary off: write ignored
    cfg_swap_off = 0; sec_osc_on = 0;
    write(8'h01);
    chk(rd_data == 8'h00, "R2", "write with secondary off", rd_data, 0);

    // permitted: upper bits discarded, switch to secondary
    sec_osc_on = 1;
    write(8'hFF);
    chk(rd_data == 8'h01, "R1", "upper bits read zero", rd_data, 1);
    sel_model = 1;
    wait_switch(1, cfg_main_mode);

    // losing permission clears the bit; RC mode returns without start-up
    @(negedge clk_main); sec_osc_on = 0;
    @(negedge clk_main);
    chk(rd_data == 8'h00, "R3", "forced clear", rd_data, 0);
    sel_model = 0;
    wait_switch(0, cfg_main_mode);

    // crystal mode return
    sec_osc_on = 1; cfg_main_mode = 3'd1;
    write(8'h01); sel_model = 1; wait_switch(1, cfg_main_mode);
    write(8'h00);
    chk(rd_data == 8'h00, "R2", "write zero", rd_data, 0);
    sel_model = 0; wait_switch(0, cfg_main_mode);

    // PLL mode return
    cfg_main_mode = 3'd3;
    write(8'h01); sel_model = 1; wait_switch(1, cfg_main_mode);
    write(8'h00); sel_model = 0; wait_switch(0, cfg_main_mode);

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      logic p, b, e;
      @(negedge clk_main);
      cfg_main_mode = 3'($urandom_range(7, 0));
      cfg_swap_off  = ($urandom_range(3, 0) == 0);
      sec_osc_on    = ($urandom_range(3, 0) != 0);
      p = !cfg_swap_off && sec_osc_on;
      @(negedge clk_main);
      e = sel_model & p;
      chk(rd_data == {7'd0, e}, "R3", "select after config change", rd_data, e);
      if (e != sel_model) begin sel_model = e; wait_switch(0, cfg_main_mode); end
      b = 1'($urandom_range(1, 0));
      write({7'($urandom_range(127, 0)), b});
      e = b & p;
      chk(rd_data == {7'd0, e}, "R2", "random write", rd_data, e);
      if (e != sel_model) begin sel_model = e; wait_switch(e, cfg_main_mode); end
    end

    chk(min_w >= TMAIN / 2.0 - 0.5, "R10", "shortest sys_clk phase ns", int'(min_w), int'(TMAIN / 2.0));
    summary();
  end
endmodule